// File: doc/BRIEF.md
# Paged Memory Address Mapper

This block widens the reach of a processor that issues 15-bit word addresses. A small programmable table of 16 entries translates the upper part of each address. Every entry holds an 8-bit page number and a 4-bit region code. The page number is joined to the untranslated low address bits to form an 18-bit physical word address. The region code is decoded into one active-low select for each of 16 memory-mapped regions.

The processor address and a program-select flag are captured into a holding register on any clock edge where the address strobe is high. Software loads the table through the processor's parallel I/O transfer path. While the captured program-select flag is high, the table is bypassed and reads as all ones. This steers the access to the boot ROM region (code 15), so that the reset vector fetch does not depend on the table contents. Reset fills every entry with all ones, so an unprogrammed entry also falls back to the boot ROM.

Port bit 14 of `cpu_addr` carries the most significant processor address line, and bit 0 carries the least significant.

Top module: `page_mapper`

## Requirements
- R1: After reset every table entry holds 12'hFFF, the held address is zero, and the outputs read `phys_addr` = 18'h3FC00 and `cs_n` = 16'h7FFF.
- R2: `cpu_addr` and `prog_sel` are captured on a rising clock edge only when `addr_strobe` is high. A change of either input while `addr_strobe` is low has no effect on the outputs.
- R3: Held bits `cpu_addr[13:10]` choose the table entry. `phys_addr` equals {entry[7:0], held `cpu_addr[9:0]`}.
- R4: `cs_n` drives exactly one bit low, the bit whose index equals entry[11:8].
- R5: While the held program-select flag is 1, the entry reads as 12'hFFF, whatever the table contents. `phys_addr[17:10]` is then 8'hFF and `cs_n` is 16'h7FFF (the boot ROM select only).
- R6: A rising edge with `io_wr` high and held `cpu_addr[14]` = 1 writes `io_data` into the entry chosen by held `cpu_addr[13:10]`. The write happens whether or not program-select is held. The outputs show the old entry up to that edge and the new entry after it.
- R7: `io_wr` with held `cpu_addr[14]` = 0 leaves every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strobe | input | 1 | Captures address and program-select when high |
| cpu_addr | input | 15 | Processor word address; bit 14 is the most significant line |
| prog_sel | input | 1 | Program-select flag; forces the boot ROM mapping |
| io_wr | input | 1 | Parallel I/O write strobe for the table |
| io_data | input | 12 | Entry to write: [11:8] region, [7:0] page |
| phys_addr | output | 18 | Translated physical word address |
| cs_n | output | 16 | Active-low region selects, one-hot low |

## Verification
The hardest case to reach from the ports is a table write that lands while program-select is held high. The outputs hide the new entry until a later cycle is captured with program-select low. The stimulus writes under bypass in both directed and random sequences, then captures the same index without bypass to show the stored value. Same-cycle old-data reads are sampled just before the write edge. Writes with the I/O bit clear are followed by a read-back of the addressed entry.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int ADDR_W   = 15;
    localparam int IDX_W    = 4;
    localparam int PAGE_W   = 8;
    localparam int REGION_W = 4;
    localparam int ENTRIES  = 1 << IDX_W;
    localparam int ENTRY_W  = PAGE_W + REGION_W;
    localparam int OFFS_W   = ADDR_W - 1 - IDX_W;
    localparam int PHYS_W   = PAGE_W + OFFS_W;
    localparam int NSEL     = 1 << REGION_W;

    typedef struct packed {
        logic [REGION_W-1:0] region;
        logic [PAGE_W-1:0]   page;
    } entry_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              psel;
    } hold_t;
endpackage

// File: rtl/pm_addr_hold.sv
module pm_addr_hold
    import pm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              psel_in,
    output logic              io_sel,
    output logic [IDX_W-1:0]  idx,
    output logic [OFFS_W-1:0] offs,
    output logic              psel
);
    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (strobe) begin
            hold_d.addr = addr_in;
            hold_d.psel = psel_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q.addr <= '0;
            hold_q.psel <= 1'b1;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign io_sel = hold_q.addr[ADDR_W-1];
    assign idx    = hold_q.addr[ADDR_W-2 -: IDX_W];
    assign offs   = hold_q.addr[OFFS_W-1:0];
    assign psel   = hold_q.psel;

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(hold_q));
endmodule

// File: rtl/pm_map_table.sv
module pm_map_table
    import pm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic               bypass,
    output entry_t             rd_entry
);
    entry_t [ENTRIES-1:0] tab_d, tab_q;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i)))
                tab_d[i] = entry_t'(wr_data);
            else
                tab_d[i] = tab_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '1;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign rd_entry = bypass ? entry_t'('1) : tab_q[rd_idx];

    // R6
    map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tab_q[$past(wr_idx)] == entry_t'($past(wr_data))));

    // R7
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tab_q));
endmodule

// File: rtl/pm_region_decode.sv
module pm_region_decode
    import pm_pkg::*;
(
    input  logic [REGION_W-1:0] region,
    output logic [NSEL-1:0]     sel_n
);
    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign sel_n[g] = (region != REGION_W'(g));
    end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import pm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_strobe,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               prog_sel,
    input  logic               io_wr,
    input  logic [ENTRY_W-1:0] io_data,
    output logic [PHYS_W-1:0]  phys_addr,
    output logic [NSEL-1:0]    cs_n
);
    logic              io_sel;
    logic [IDX_W-1:0]  idx;
    logic [OFFS_W-1:0] offs;
    logic              psel;
    entry_t            entry;

    pm_addr_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (addr_strobe),
        .addr_in (cpu_addr),
        .psel_in (prog_sel),
        .io_sel  (io_sel),
        .idx     (idx),
        .offs    (offs),
        .psel    (psel)
    );

    pm_map_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (io_wr & io_sel),
        .wr_idx   (idx),
        .wr_data  (io_data),
        .rd_idx   (idx),
        .bypass   (psel),
        .rd_entry (entry)
    );

    pm_region_decode u_dec (
        .region (entry.region),
        .sel_n  (cs_n)
    );

    assign phys_addr = {entry.page, offs};

    // R4
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) == 1);

    // R5
    boot_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel |-> (cs_n == {1'b0, {(NSEL-1){1'b1}}} && phys_addr[PHYS_W-1 -: PAGE_W] == '1));
endmodule

// File: tb/page_mapper_bench.sv
`timescale 1ns/1ps
module page_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_strobe = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic        prog_sel = 1'b0;
    logic        io_wr = 1'b0;
    logic [11:0] io_data = '0;
    logic [17:0] phys_addr;
    logic [15:0] cs_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [11:0] exp_tab [16];
    logic [14:0] m_addr = '0;
    logic        m_psel = 1'b1;

    always #4 clk = ~clk;

    page_mapper u_page_mapper (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .cpu_addr(cpu_addr),
        .prog_sel(prog_sel), .io_wr(io_wr), .io_data(io_data),
        .phys_addr(phys_addr), .cs_n(cs_n)
    );

    function automatic logic [11:0] m_entry();
        return m_psel ? 12'hFFF : exp_tab[m_addr[13:10]];
    endfunction

    function automatic logic [17:0] m_phys();
        logic [11:0] e = m_entry();
        return {e[7:0], m_addr[9:0]};
    endfunction

    function automatic logic [15:0] m_cs();
        logic [11:0] e = m_entry();
        return ~(16'h1 << e[11:8]);
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_out(string req);
        check(req, 32'(phys_addr), 32'(m_phys()));
        check(req, 32'(cs_n), 32'(m_cs()));
    endtask

    task automatic capture(logic [14:0] a, logic p);
        @(negedge clk);
        cpu_addr = a; prog_sel = p; addr_strobe = 1'b1;
        @(negedge clk);
        addr_strobe = 1'b0;
        m_addr = a; m_psel = p;
    endtask

    // drive write at current negedge; check old value before edge, new after
    task automatic io_write(logic [11:0] d, string req);
        io_wr = 1'b1; io_data = d;
        #1 check_out({req, " old before edge"});
        @(negedge clk);
        io_wr = 1'b0;
        if (m_addr[14]) exp_tab[m_addr[13:10]] = d;
        check_out(req);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 16; i++) exp_tab[i] = 12'hFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 phys", 32'(phys_addr), 32'h3FC00);
        check("R1 cs", 32'(cs_n), 32'h7FFF);

        // R1 unprogrammed entry falls to boot ROM without bypass
        capture(15'h1234, 1'b0);
        check_out("R1 unprogrammed");

        // R6 program every entry, then R3/R4 read each back
        for (int i = 0; i < 16; i++) begin
            capture({1'b1, 4'(i), 10'h000}, 1'b0);
            io_write({4'(15 - i), 8'(8'hA0 + i)}, "R6 fill");
        end
        for (int i = 0; i < 16; i++) begin
            capture({1'b0, 4'(i), 10'(i * 37)}, 1'b0);
            check_out("R3 R4 readback");
        end

        // R7 write with bit 14 clear is ignored
        capture(15'h0C55, 1'b0);
        io_write(12'h123, "R7 ignored");
        capture(15'h0C00, 1'b0);
        check_out("R7 entry intact");

        // R5 bypass hides table; R6 write under bypass then seen later
        capture(15'h4A00, 1'b1);
        check_out("R5 bypass");
        io_write(12'h5C3, "R6 under bypass");
        capture(15'h4A11, 1'b0);
        check_out("R6 after bypass");

        // R2 inputs ignored while strobe low
        @(negedge clk);
        cpu_addr = 15'h7FFF; prog_sel = 1'b1;
        @(negedge clk);
        check_out("R2 strobe low");

        // random mix
        for (int k = 0; k < 1500; k++) begin
            int op = int'($urandom % 4);
            logic [14:0] a = 15'($urandom);
            logic p = ($urandom % 4) == 0;
            case (op)
                0, 1: begin capture(a, p); check_out("R3 R4 R5 random"); end
                2: begin capture(a, p); io_write(12'($urandom), a[14] ? "R6 random" : "R7 random"); end
                default: begin
                    @(negedge clk);
                    cpu_addr = 15'($urandom); prog_sel = $urandom % 2;
                    @(negedge clk);
                    check_out("R2 random");
                end
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule